// File: doc/BRIEF.md
# Dual Two-Stage Synchronizing Flip-Flop

This block holds a number of independent synchronizer channels. Two is the default. Each channel takes an asynchronous data bit and carries it through a cascade of flip-flop stages clocked by that channel's own rising-edge clock. The bit therefore reaches the channel's outputs two clock edges after it is captured. Each channel drives a true output and a complementary output.

Two active-low controls act on each channel without reference to its clock. The preset control loads ones into every stage of the cascade, and the clear control loads zeros into every stage. Because the whole cascade is loaded, no stale bit is left in the first stage to appear after the control is released. While both controls are low, the channel drives both of its outputs high. That condition ends as soon as either control goes high again:

- If clear is released first, preset takes over and every stage becomes one.
- If preset is released first, clear stays in charge and every stage remains zero.
- If both are released together, clear wins and every stage is left at zero.

Each channel is governed by a small mode machine, decoded from the levels of its two controls:

| Mode | Controls | Outputs |
|------|----------|---------|
| `CH_TRACK` | both high | follow the last stage |
| `CH_PRESET` | preset low, clear high | Q=1, Q-bar=0 |
| `CH_CLEAR` | clear low, preset high | Q=0, Q-bar=1 |
| `CH_CONTEND` | both low | Q=1, Q-bar=1 |

The named transitions between modes are:

- **assert-preset**: `CH_TRACK` to `CH_PRESET`.
- **assert-clear**: `CH_TRACK` to `CH_CLEAR`.
- **collide**: `CH_PRESET` or `CH_CLEAR` to `CH_CONTEND`.
- **hand-to-preset**: `CH_CONTEND` to `CH_PRESET`. The stages are reloaded with ones.
- **hand-to-clear**: `CH_CONTEND` to `CH_CLEAR`.
- **joint-release**: `CH_CONTEND` to `CH_TRACK`. The stages stay at zero.
- **release**: `CH_PRESET` or `CH_CLEAR` to `CH_TRACK`.

Top module: `dual_sync_ff`

## Requirements
- R1: Channels are independent: clocking, data or control activity on one channel never changes the outputs of another.
- R2: With both controls high, Q after a rising clock edge equals the data bit sampled two rising edges earlier, with the default depth of two stages.
- R3: With both controls high and no rising clock edge, Q and Q-bar hold their values while the data input toggles.
- R4: Preset low with clear high sets Q=1 and Q-bar=0 at once, without a clock edge. Clock edges during this mode leave the outputs unchanged.
- R5: Clear low with preset high sets Q=0 and Q-bar=1 at once, without a clock edge. This is also the state seen out of reset.
- R6: Preset or clear loads every stage. After the control is released, the first clock edge still shows the forced value on Q, and the data bit appears only on the second edge.
- R7: Preset and clear both low drives Q=1 and Q-bar=1.
- R8: From the both-low mode, the control that stays low decides all stages. Releasing clear first leaves ones in every stage, and releasing preset first leaves zeros.
- R9: Releasing both controls in the same instant from the both-low mode leaves zeros in every stage.
- R10: Outside the both-low mode, Q-bar is always the inverse of Q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | NUM_CH | Per-channel rising-edge clock |
| set_n_i | input | NUM_CH | Per-channel asynchronous preset, active low |
| clr_n_i | input | NUM_CH | Per-channel asynchronous clear, active low |
| d_i | input | NUM_CH | Per-channel asynchronous data bit |
| q_o | output | NUM_CH | Per-channel true output |
| qb_o | output | NUM_CH | Per-channel complementary output |

## Verification
The bench builds the block with its defaults: two channels and two stages per channel. With only two stage bits per channel, a sweep of every 4-bit data pattern covers each combination of stage contents, including the case of both stages holding mixed values. The bench also walks every ordering of control release out of the both-low mode. A long random mix of clock, data and control events on both channels is then compared against a stage-by-stage model, and that mix also exercises cross-channel independence.

// File: rtl/dsync_pkg.sv
package dsync_pkg;

    // Channel mode, decoded from the levels of the two active-low controls.
    typedef enum logic [1:0] {
        CH_TRACK   = 2'b00,
        CH_PRESET  = 2'b01,
        CH_CLEAR   = 2'b10,
        CH_CONTEND = 2'b11
    } ch_mode_e;

    function automatic ch_mode_e decode_mode(input logic set_n, input logic clr_n);
        ch_mode_e m;
        unique case ({set_n, clr_n})
            2'b11:   m = CH_TRACK;
            2'b01:   m = CH_PRESET;
            2'b10:   m = CH_CLEAR;
            default: m = CH_CONTEND;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dsync_ctl_dec.sv
module dsync_ctl_dec
    import dsync_pkg::*;
(
    input  logic     set_n,
    input  logic     clr_n,
    output ch_mode_e mode,
    output logic     pre_eff_n
);

    always_comb begin
        mode = decode_mode(set_n, clr_n);
    end

    // The preset is seen by the stages only while the clear is inactive.
    // When the clear rises with the preset still low, this signal falls,
    // so the stages are reloaded with ones at once.
    assign pre_eff_n = set_n | ~clr_n;

endmodule

// File: rtl/dsync_chain.sv
module dsync_chain #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic pre_n,
    input  logic d,
    output logic last
);

    localparam int TOP = DEPTH - 1;

    logic [TOP:0] stg;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
                if (!clr_n) begin
                    stg <= '0;
                end else if (!pre_n) begin
                    stg <= '1;
                end else begin
                    stg <= d;
                end
            end
        end else begin : g_cascade
            always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
                if (!clr_n) begin
                    stg <= '0;
                end else if (!pre_n) begin
                    stg <= '1;
                end else begin
                    stg <= {stg[TOP-1:0], d};
                end
            end
        end
    endgenerate

    assign last = stg[TOP];

endmodule

// File: rtl/dsync_out_drv.sv
module dsync_out_drv
    import dsync_pkg::*;
(
    input  ch_mode_e mode,
    input  logic     last,
    output logic     q,
    output logic     qb
);

    always_comb begin
        unique case (mode)
            CH_TRACK: begin
                q  = last;
                qb = ~last;
            end
            CH_PRESET: begin
                q  = 1'b1;
                qb = 1'b0;
            end
            CH_CLEAR: begin
                q  = 1'b0;
                qb = 1'b1;
            end
            CH_CONTEND: begin
                q  = 1'b1;
                qb = 1'b1;
            end
            default: begin
                q  = 1'b1;
                qb = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dsync_channel.sv
module dsync_channel
    import dsync_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic set_n,
    input  logic clr_n,
    input  logic d,
    output logic q,
    output logic qb
);

    ch_mode_e mode;
    logic     pre_eff_n;
    logic     last;

    dsync_ctl_dec u_dec (
        .set_n     (set_n),
        .clr_n     (clr_n),
        .mode      (mode),
        .pre_eff_n (pre_eff_n)
    );

    dsync_chain #(.DEPTH(DEPTH)) u_chain (
        .clk   (clk),
        .clr_n (clr_n),
        .pre_n (pre_eff_n),
        .d     (d),
        .last  (last)
    );

    dsync_out_drv u_out (
        .mode (mode),
        .last (last),
        .q    (q),
        .qb   (qb)
    );

endmodule

// File: rtl/dual_sync_ff.sv
module dual_sync_ff #(
    parameter int NUM_CH     = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic [NUM_CH-1:0] clk_i,
    input  logic [NUM_CH-1:0] set_n_i,
    input  logic [NUM_CH-1:0] clr_n_i,
    input  logic [NUM_CH-1:0] d_i,
    output logic [NUM_CH-1:0] q_o,
    output logic [NUM_CH-1:0] qb_o
);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dsync_channel #(.DEPTH(SYNC_DEPTH)) u_ch (
                .clk   (clk_i[c]),
                .set_n (set_n_i[c]),
                .clr_n (clr_n_i[c]),
                .d     (d_i[c]),
                .q     (q_o[c]),
                .qb    (qb_o[c])
            );
        end
    endgenerate

endmodule

// File: rtl/dual_sync_ff_chk.sv
module dual_sync_ff_chk #(
    parameter int NUM_CH     = 2,
    parameter int SYNC_DEPTH = 2
) (
    input logic [NUM_CH-1:0] clk_i,
    input logic [NUM_CH-1:0] set_n_i,
    input logic [NUM_CH-1:0] clr_n_i,
    input logic [NUM_CH-1:0] d_i,
    input logic [NUM_CH-1:0] q_o,
    input logic [NUM_CH-1:0] qb_o
);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic       live = 1'b0;
            logic       ctl_ok;
            logic [1:0] run_cnt;

            assign ctl_ok = set_n_i[c] & clr_n_i[c];

            always_ff @(posedge clk_i[c]) begin
                live <= 1'b1;
            end

            // Counts consecutive edges with both controls released.
            always_ff @(posedge clk_i[c] or negedge ctl_ok) begin
                if (!ctl_ok) begin
                    run_cnt <= 2'd0;
                end else if (run_cnt != 2'd3) begin
                    run_cnt <= run_cnt + 2'd1;
                end
            end

            assert_preset_R4: assert property (@(posedge clk_i[c]) disable iff (!live)
                (!set_n_i[c] && clr_n_i[c]) |-> (q_o[c] && !qb_o[c]))
                else $error("R4 preset output wrong on channel %0d", c);

            assert_clear_R5: assert property (@(posedge clk_i[c]) disable iff (!live)
                (set_n_i[c] && !clr_n_i[c]) |-> (!q_o[c] && qb_o[c]))
                else $error("R5 clear output wrong on channel %0d", c);

            assert_contend_R7: assert property (@(posedge clk_i[c]) disable iff (!live)
                (!set_n_i[c] && !clr_n_i[c]) |-> (q_o[c] && qb_o[c]))
                else $error("R7 both-low output wrong on channel %0d", c);

            assert_complement_R10: assert property (@(posedge clk_i[c]) disable iff (!live)
                (set_n_i[c] || clr_n_i[c]) |-> (q_o[c] != qb_o[c]))
                else $error("R10 outputs not complementary on channel %0d", c);

            if (SYNC_DEPTH == 2) begin : g_lat
                assert_latency_R2: assert property (@(posedge clk_i[c]) disable iff (!live)
                    (run_cnt >= 2'd2) |-> (q_o[c] == $past(d_i[c], 2)))
                    else $error("R2 two-edge latency broken on channel %0d", c);
            end
        end
    endgenerate

endmodule

bind dual_sync_ff dual_sync_ff_chk #(.NUM_CH(NUM_CH), .SYNC_DEPTH(SYNC_DEPTH)) chk_i (.*);

// File: tb/dual_sync_ff_tb_top.sv
module dual_sync_ff_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic [1:0] clk;
    logic [1:0] set_n;
    logic [1:0] clr_n;
    logic [1:0] d;
    logic [1:0] q;
    logic [1:0] qb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit m_s0 [2];
    bit m_s1 [2];

    dual_sync_ff #(.NUM_CH(2), .SYNC_DEPTH(2)) dut_i (
        .clk_i   (clk),
        .set_n_i (set_n),
        .clr_n_i (clr_n),
        .d_i     (d),
        .q_o     (q),
        .qb_o    (qb)
    );

    // Expected outputs follow R7 for both-low, otherwise the modelled last stage (R10).
    task automatic check_one(input int c, input string tag);
        logic eq;
        logic eqb;
        if (!set_n[c] && !clr_n[c]) begin
            eq  = 1'b1;
            eqb = 1'b1;
        end else begin
            eq  = m_s1[c];
            eqb = !m_s1[c];
        end
        checks++;
        if (q[c] !== eq || qb[c] !== eqb) begin
            errors++;
            $display("FAIL %s ch%0d: q=%b qb=%b, expected q=%b qb=%b", tag, c, q[c], qb[c], eq, eqb);
        end
    endtask

    task automatic check_all(input string tag);
        check_one(0, tag);
        check_one(1, tag);
    endtask

    task automatic tick(input int c);
        if (set_n[c] && clr_n[c]) begin
            m_s1[c] = m_s0[c];
            m_s0[c] = d[c];
        end
        clk[c] = 1'b1;
        #HALF;
        clk[c] = 1'b0;
        #HALF;
    endtask

    task automatic drive_d(input int c, input bit v);
        d[c] = v;
        #1;
    endtask

    task automatic drive_ctl(input int c, input bit s, input bit r);
        if (!set_n[c] && !clr_n[c] && s && r) begin
            $display("WARNING ch%0d: preset and clear released together, clear wins", c);
        end
        set_n[c] = s;
        clr_n[c] = r;
        if (!r) begin
            m_s0[c] = 1'b0;
            m_s1[c] = 1'b0;
        end else if (!s) begin
            m_s0[c] = 1'b1;
            m_s1[c] = 1'b1;
        end
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clk   = 2'b00;
        d     = 2'b00;
        set_n = 2'b11;
        clr_n = 2'b00;
        for (int i = 0; i < 2; i++) begin
            m_s0[i] = 1'b0;
            m_s1[i] = 1'b0;
        end
        #3;
        check_all("R5 reset state");
        drive_ctl(0, 1'b1, 1'b1);
        drive_ctl(1, 1'b1, 1'b1);
        check_all("R5 after release");

        // R2 / R3 / R1: every 4-bit pattern on each channel
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 16; p++) begin
                for (int b = 0; b < 4; b++) begin
                    drive_d(c, p[b]);
                    tick(c);
                    check_one(c, "R2 latency");
                    check_one(1 - c, "R1 other channel");
                    drive_d(c, !p[b]);
                    check_one(c, "R3 hold");
                end
            end
        end

        // R4 and R6 on channel 0
        drive_ctl(0, 1'b0, 1'b1);
        check_one(0, "R4 preset");
        check_one(1, "R1 other channel");
        tick(0);
        check_one(0, "R4 clock ignored");
        drive_ctl(0, 1'b1, 1'b1);
        drive_d(0, 1'b0);
        tick(0);
        check_one(0, "R6 first stage preset");
        tick(0);
        check_one(0, "R6 data arrives");

        // R5 and R6 with clear
        drive_d(0, 1'b1);
        tick(0);
        tick(0);
        check_one(0, "R2 primed high");
        drive_ctl(0, 1'b1, 1'b0);
        check_one(0, "R5 clear");
        tick(0);
        check_one(0, "R5 clock ignored");
        drive_ctl(0, 1'b1, 1'b1);
        tick(0);
        check_one(0, "R6 first stage cleared");
        tick(0);
        check_one(0, "R6 data arrives");

        // R7 and R8 on channel 1
        drive_ctl(1, 1'b0, 1'b1);
        drive_ctl(1, 1'b0, 1'b0);
        check_one(1, "R7 both low");
        check_one(0, "R1 other channel");
        drive_ctl(1, 1'b0, 1'b1);
        check_one(1, "R8 clear released first");
        drive_ctl(1, 1'b1, 1'b1);
        drive_d(1, 1'b0);
        tick(1);
        check_one(1, "R8 stages hold ones");
        tick(1);
        check_one(1, "R8 data arrives");
        drive_ctl(1, 1'b0, 1'b0);
        check_one(1, "R7 both low again");
        drive_ctl(1, 1'b1, 1'b0);
        check_one(1, "R8 preset released first");
        drive_ctl(1, 1'b1, 1'b1);
        drive_d(1, 1'b1);
        tick(1);
        check_one(1, "R8 stages hold zeros");

        // R9: joint release
        drive_ctl(1, 1'b0, 1'b0);
        drive_ctl(1, 1'b1, 1'b1);
        check_one(1, "R9 joint release");
        tick(1);
        check_one(1, "R9 first stage zero");
        tick(1);
        check_one(1, "R9 data arrives");

        // Random mix, R10 complement checked on every sample
        for (int k = 0; k < 800; k++) begin
            int c;
            int op;
            c  = int'($urandom_range(0, 1));
            op = int'($urandom_range(0, 5));
            if (op < 3) begin
                tick(c);
            end else if (op == 3) begin
                drive_d(c, bit'($urandom_range(0, 1)));
            end else begin
                drive_ctl(c, ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0));
            end
            check_all("R10 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule